// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block keeps the interrupt status and interrupt mask of an SPI controller that has a transmit byte FIFO and a receive byte FIFO. The block does not contain the FIFOs. It watches their occupancy counts and full flags, and it also receives single-cycle event pulses for transmit underflow, receive overflow and mode fail. From these it keeps a seven-bit status word and drives one level-sensitive interrupt request.

The status word has two kinds of bits. Four are level bits, which are evaluated again on every clock: two come from the full flags and two come from comparing the FIFO counts against programmable thresholds. Three are sticky bits: an event pulse sets one and it stays set until software clears it. Software cannot write the mask directly. It sets mask bits through one register and clears them through another. Reading the status register clears it.

A freeze input holds the whole status word while a linear-read mode is active. Software clears still apply during the freeze.

Top module: `spi_irq_status_unit`

## Requirements
- R1: After reset the mask is 0, the status is 0, both thresholds are 1, and `irq` is low.
- R2: The level bits are status bit 5 (equals `rx_full`), bit 4 (`rx_count` >= receive threshold), bit 3 (equals `tx_full`) and bit 2 (`tx_count` < transmit threshold). They follow the inputs sampled at the previous clock edge.
- R3: A one-cycle pulse sets a sticky bit. `ev_tx_under` sets bit 6, `ev_mode_fail` sets bit 1 and `ev_rx_over` sets bit 0. A sticky bit stays set until it is cleared.
- R4: A write to offset 0x04 clears each status bit whose data bit is 1 and leaves every other bit unchanged.
- R5: A read of offset 0x04 returns the 7-bit status in `rdata[6:0]` in the same cycle, then clears the whole status word at the clock edge. Level bits are evaluated again in that same update.
- R6: If an event pulse arrives in the same cycle as a write-clear or read-clear of its bit, the bit ends up set.
- R7: A write to offset 0x08 ORs `wdata[6:0]` into the mask. A write to 0x0C clears from the mask the bits that `wdata[6:0]` has at 1. Offset 0x10 reads the mask. A write to 0x10 has no effect.
- R8: `irq` is high exactly when the mask AND the status is nonzero.
- R9: The transmit threshold is at 0x28 and the receive threshold is at 0x2C. Each holds `CNT_W` bits, loads from `wdata[CNT_W-1:0]`, and reads back zero-extended.
- R10: While `lin_mode` is high, no status bit can become set: event pulses and FIFO inputs are ignored. Write-clears and read-clears still take effect.
- R11: Offsets 0x08, 0x0C and any unmapped offset read as 0. Register bits above a field's width read as 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lin_mode | input | 1 | Freezes status updates while high |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| ev_tx_under | input | 1 | Transmit underflow pulse |
| ev_rx_over | input | 1 | Receive overflow pulse |
| ev_mode_fail | input | 1 | Mode fail pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A lost sticky bit, or a clear that misses its target, shows up at the first status read that follows. An interrupt that should fire also fails to rise one clock after the event. A wrong threshold comparison appears as a wrong bit 2 or bit 4 one clock after the counts change. The bench sweeps every count against several threshold values, including 0 and the maximum, so off-by-one errors on either side of the comparison are caught. If a mask register is corrupted, `irq` becomes wrong within the same cycle, and the mask readback exposes the bad value directly.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int STAT_W = 7;

    localparam int BIT_TX_UNDER  = 6;
    localparam int BIT_RX_FULL   = 5;
    localparam int BIT_RX_AVAIL  = 4;
    localparam int BIT_TX_FULL   = 3;
    localparam int BIT_TX_ROOM   = 2;
    localparam int BIT_MODE_FAIL = 1;
    localparam int BIT_RX_OVER   = 0;

    localparam logic [STAT_W-1:0] STICKY_BITS = 7'b100_0011;
    localparam logic [STAT_W-1:0] LEVEL_BITS  = 7'b011_1100;

    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_ENABLE  = 8'h08;
    localparam logic [7:0] OFS_DISABLE = 8'h0C;
    localparam logic [7:0] OFS_MASK    = 8'h10;
    localparam logic [7:0] OFS_TX_THR  = 8'h28;
    localparam logic [7:0] OFS_RX_THR  = 8'h2C;

endpackage

// File: rtl/spi_irq_level_eval.sv
module spi_irq_level_eval
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic [CNT_W-1:0]  tx_thr,
    input  logic [CNT_W-1:0]  rx_thr,
    output logic [STAT_W-1:0] level
);

    always_comb begin
        level               = '0;
        level[BIT_RX_FULL]  = rx_full;
        level[BIT_RX_AVAIL] = (rx_count >= rx_thr);
        level[BIT_TX_FULL]  = tx_full;
        level[BIT_TX_ROOM]  = (tx_count < tx_thr);
    end

endmodule

// File: rtl/spi_irq_access.sv
module spi_irq_access
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    input  logic [CNT_W-1:0]  tx_thr,
    input  logic [CNT_W-1:0]  rx_thr,
    output logic [STAT_W-1:0] stat_clr,
    output logic [STAT_W-1:0] mask_set,
    output logic [STAT_W-1:0] mask_clr,
    output logic              tx_thr_we,
    output logic              rx_thr_we,
    output logic [CNT_W-1:0]  thr_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int USED_W = (STAT_W > CNT_W) ? STAT_W : CNT_W;

    logic hit_status, hit_enable, hit_disable, hit_mask, hit_tx_thr, hit_rx_thr;
    logic unused_wdata_hi;

    assign hit_status  = (addr == ADDR_W'(OFS_STATUS));
    assign hit_enable  = (addr == ADDR_W'(OFS_ENABLE));
    assign hit_disable = (addr == ADDR_W'(OFS_DISABLE));
    assign hit_mask    = (addr == ADDR_W'(OFS_MASK));
    assign hit_tx_thr  = (addr == ADDR_W'(OFS_TX_THR));
    assign hit_rx_thr  = (addr == ADDR_W'(OFS_RX_THR));

    assign unused_wdata_hi = ^wdata[DATA_W-1:USED_W];

    always_comb begin
        stat_clr  = '0;
        mask_set  = '0;
        mask_clr  = '0;
        if (wr_en && hit_status)  stat_clr = wdata[STAT_W-1:0];
        if (rd_en && hit_status)  stat_clr = '1;
        if (wr_en && hit_enable)  mask_set = wdata[STAT_W-1:0];
        if (wr_en && hit_disable) mask_clr = wdata[STAT_W-1:0];
        tx_thr_we = wr_en && hit_tx_thr;
        rx_thr_we = wr_en && hit_rx_thr;
        thr_wdata = wdata[CNT_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (hit_status)      rdata = DATA_W'(status);
        else if (hit_mask)   rdata = DATA_W'(mask);
        else if (hit_tx_thr) rdata = DATA_W'(tx_thr);
        else if (hit_rx_thr) rdata = DATA_W'(rx_thr);
    end

endmodule

// File: rtl/spi_irq_status_unit.sv
module spi_irq_status_unit
    import spi_irq_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lin_mode,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_tx_under,
    input  logic              ev_rx_over,
    input  logic              ev_mode_fail,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic [CNT_W-1:0]  tx_thr;
        logic [CNT_W-1:0]  rx_thr;
    } irq_state_t;

    localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(1);

    irq_state_t st_d, st_q;

    logic [STAT_W-1:0] level_w;
    logic [STAT_W-1:0] events_w;
    logic [STAT_W-1:0] stat_clr_w, mask_set_w, mask_clr_w;
    logic              tx_thr_we_w, rx_thr_we_w;
    logic [CNT_W-1:0]  thr_wdata_w;
    logic [STAT_W-1:0] status_w, mask_w;

    spi_irq_level_eval #(.CNT_W(CNT_W)) u_level (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_full  (tx_full),
        .rx_full  (rx_full),
        .tx_thr   (st_q.tx_thr),
        .rx_thr   (st_q.rx_thr),
        .level    (level_w)
    );

    spi_irq_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_access (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .status    (st_q.status),
        .mask      (st_q.mask),
        .tx_thr    (st_q.tx_thr),
        .rx_thr    (st_q.rx_thr),
        .stat_clr  (stat_clr_w),
        .mask_set  (mask_set_w),
        .mask_clr  (mask_clr_w),
        .tx_thr_we (tx_thr_we_w),
        .rx_thr_we (rx_thr_we_w),
        .thr_wdata (thr_wdata_w),
        .rdata     (rdata)
    );

    always_comb begin
        events_w                = '0;
        events_w[BIT_TX_UNDER]  = ev_tx_under;
        events_w[BIT_MODE_FAIL] = ev_mode_fail;
        events_w[BIT_RX_OVER]   = ev_rx_over;
    end

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < STAT_W; b++) begin
            if (lin_mode) begin
                st_d.status[b] = st_q.status[b] & ~stat_clr_w[b];
            end else if (LEVEL_BITS[b]) begin
                st_d.status[b] = level_w[b];
            end else begin
                st_d.status[b] = (st_q.status[b] & ~stat_clr_w[b]) | events_w[b];
            end
        end
        st_d.mask = (st_q.mask | mask_set_w) & ~mask_clr_w;
        if (tx_thr_we_w) st_d.tx_thr = thr_wdata_w;
        if (rx_thr_we_w) st_d.rx_thr = thr_wdata_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '0;
            st_q.tx_thr <= THR_RESET;
            st_q.rx_thr <= THR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_w = st_q.status;
    assign mask_w   = st_q.mask;
    assign irq      = |(st_q.status & st_q.mask);

endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lin_mode,
    input logic              ev_tx_under,
    input logic              ev_rx_over,
    input logic              rx_full,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] mask
);

    logic at_status, at_mask;
    assign at_status = (addr == ADDR_W'(OFS_STATUS));
    assign at_mask   = (addr == ADDR_W'(OFS_MASK));

    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_under && !lin_mode) |=> status[BIT_TX_UNDER]);

    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_TX_UNDER] && !(at_status && (rd_en || wr_en)))
        |=> status[BIT_TX_UNDER]);

    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_over && !lin_mode && rd_en && at_status) |=> status[BIT_RX_OVER]);

    p_level_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_mode |=> (status[BIT_RX_FULL] == $past(rx_full)));

    p_frozen_no_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lin_mode |=> ((status & ~$past(status)) == '0));

    p_mask_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_mask) |=> (mask == $past(mask)));

    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

bind spi_irq_status_unit spi_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lin_mode    (lin_mode),
    .ev_tx_under (ev_tx_under),
    .ev_rx_over  (ev_rx_over),
    .rx_full     (rx_full),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .irq         (irq),
    .status      (status_w),
    .mask        (mask_w)
);

// File: tb/test_spi_irq_status_unit.sv
`timescale 1ns/1ps
module test_spi_irq_status_unit;

    localparam int CNT_W  = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lin_mode = 1'b0;
    logic [CNT_W-1:0]  tx_count = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              tx_full = 1'b0;
    logic              rx_full = 1'b0;
    logic              ev_tx_under = 1'b0;
    logic              ev_rx_over = 1'b0;
    logic              ev_mode_fail = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_irq_status_unit #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_spi_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode),
        .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full), .rx_full(rx_full),
        .ev_tx_under(ev_tx_under), .ev_rx_over(ev_rx_over), .ev_mode_fail(ev_mode_fail),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [DATA_W-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        #0.5 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 6) ev_tx_under = 1'b1;
        if (which == 1) ev_mode_fail = 1'b1;
        if (which == 0) ev_rx_over = 1'b1;
        @(negedge clk);
        ev_tx_under = 1'b0; ev_mode_fail = 1'b0; ev_rx_over = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] lvl(int txc, int rxc, int thr_t, int thr_r, bit tf, bit rf);
        return DATA_W'((rf << 5) | ((rxc >= thr_r) << 4) | (tf << 3) | ((txc < thr_t) << 2));
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] v;
        int thr_list[5] = '{0, 1, 5, 32, CMAX};

        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1 irq in reset", DATA_W'(irq), 0);
        rst_n = 1'b1;
        rd(8'h10, v); check("R1 mask after reset", v, 0);
        rd(8'h28, v); check("R1 tx threshold reset", v, 1);
        rd(8'h2C, v); check("R1 rx threshold reset", v, 1);
        check("R1 irq after reset", DATA_W'(irq), 0);

        // R2, R9: sweep counts against thresholds
        foreach (thr_list[k]) begin
            wr(8'h28, DATA_W'(thr_list[k]));
            wr(8'h2C, DATA_W'(thr_list[k]));
            rd(8'h28, v); check("R9 tx threshold readback", v, DATA_W'(thr_list[k]));
            rd(8'h2C, v); check("R9 rx threshold readback", v, DATA_W'(thr_list[k]));
            for (int c = 0; c <= CMAX; c++) begin
                @(negedge clk);
                tx_count = CNT_W'(c);
                rx_count = CNT_W'(CMAX - c);
                tx_full  = c[1];
                rx_full  = c[0];
                rd(8'h04, v);
                check("R2 level bits", v, lvl(c, CMAX - c, thr_list[k], thr_list[k], c[1], c[0]));
            end
        end
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R9 threshold width limit", v, DATA_W'(CMAX));

        // baseline: no level bit asserted
        @(negedge clk);
        tx_count = 10; rx_count = 0; tx_full = 0; rx_full = 0;
        wr(8'h28, 1); wr(8'h2C, 1);
        rd(8'h04, v); check("R2 baseline levels zero", v, 0);

        // R3: sticky bits
        pulse(6); pulse(1); pulse(0);
        repeat (3) @(negedge clk);
        rd(8'h10, v);
        rd(8'h04, v); check("R3 sticky bits held", v, 32'h43);
        // R5: read cleared them
        rd(8'h04, v); check("R5 read clears status", v, 0);

        // R4: write one to clear
        pulse(6); pulse(1); pulse(0);
        wr(8'h04, 32'h02);
        rd(8'h04, v); check("R4 write clears only ones", v, 32'h41);

        // R6: event wins over read-clear
        @(negedge clk);
        ev_rx_over = 1'b1; rd_en = 1'b1; addr = ADDR_W'(8'h04);
        @(negedge clk);
        ev_rx_over = 1'b0; rd_en = 1'b0;
        rd(8'h04, v); check("R6 event beats read clear", v, 32'h01);
        // R6: event wins over write-clear
        @(negedge clk);
        ev_mode_fail = 1'b1; wr_en = 1'b1; addr = ADDR_W'(8'h04); wdata = 32'h7F;
        @(negedge clk);
        ev_mode_fail = 1'b0; wr_en = 1'b0;
        rd(8'h04, v); check("R6 event beats write clear", v, 32'h02);

        // R7, R11: mask access
        wr(8'h08, 32'h41);
        rd(8'h10, v); check("R7 enable sets mask", v, 32'h41);
        wr(8'h0C, 32'h01);
        rd(8'h10, v); check("R7 disable clears mask", v, 32'h40);
        wr(8'h10, 32'h7F);
        rd(8'h10, v); check("R7 mask write ignored", v, 32'h40);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R11 mask upper bits zero", v, 32'h7F);
        rd(8'h08, v); check("R11 enable reads zero", v, 0);
        rd(8'h0C, v); check("R11 disable reads zero", v, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); check("R11 unmapped reads zero", v, 0);
        rd(8'h10, v); check("R11 unmapped write no effect", v, 32'h7F);
        wr(8'h0C, 32'h7F);

        // R8: interrupt line
        wr(8'h08, 32'h04);
        @(negedge clk); tx_count = 0;
        @(negedge clk);
        check("R8 irq on level bit", DATA_W'(irq), 1);
        tx_count = 10;
        @(negedge clk);
        check("R8 irq drops with level", DATA_W'(irq), 0);
        wr(8'h0C, 32'h04);
        wr(8'h08, 32'h40);
        pulse(6);
        check("R8 irq on sticky bit", DATA_W'(irq), 1);
        wr(8'h04, 32'h40);
        check("R8 irq cleared with status", DATA_W'(irq), 0);
        pulse(0);
        check("R8 unmasked bit no irq", DATA_W'(irq), 0);
        rd(8'h04, v);

        // R10: freeze
        pulse(6);
        @(negedge clk); lin_mode = 1'b1;
        pulse(1);
        @(negedge clk); rx_full = 1'b1; tx_count = 0;
        repeat (2) @(negedge clk);
        rd(8'h04, v); check("R10 frozen status held", v, 32'h40);
        rd(8'h04, v); check("R10 clear applies while frozen", v, 0);
        @(negedge clk); lin_mode = 1'b0;
        rd(8'h04, v); rd(8'h04, v);
        check("R10 levels resume after freeze", v, 32'h24);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule